// File: doc/BRIEF.md
# Programmable 3x3 Gradient Edge Detector

This block takes a raster stream of 8-bit greyscale pixels and marks each pixel as edge or non-edge. The pixels arrive with a valid strobe, a start-of-frame marker on the first pixel of a frame and an end-of-line marker on the last pixel of each line. Two internal line delays assemble a 3x3 neighbourhood around every pixel. Two 3x3 kernels are applied to that neighbourhood, giving a horizontal and a vertical weighted sum. The sum of their absolute values is compared with a threshold.

Both kernels and the threshold sit behind a small write port. The same pipeline can therefore run a Sobel operator (the reset contents), a Prewitt operator or a custom kernel. New settings are held in shadow registers and copied into the working set only on an accepted start-of-frame, so a frame never mixes two configurations. Every accepted input pixel yields exactly one output strobe, in input order. Pixels on the frame border have no full neighbourhood, and their flag is forced low.

Top module: `edge3x3_det`

## Requirements
- R1: The neighbourhood is indexed k = 3*row + col (k = 0..8, row 0 on top, col 0 on the left) around the centre pixel at k = 4. The result belongs to that centre. There is one output strobe per accepted input pixel, and the strobes come in input order.
- R2: Each kernel sum is the sum over k of pixel(k)*coef(k), with signed 4-bit coefficients taken from cfg_data[3:0]. Address 0..8 writes horizontal coefficient k = addr, address 9..17 writes vertical coefficient k = addr-9, and address 18 writes the threshold from cfg_data[11:0]. Writes to addresses 19..31 change nothing.
- R3: After reset the horizontal kernel holds rows (-1,0,1), (-2,0,2), (-1,0,1), the vertical kernel holds rows (1,2,1), (0,0,0), (-1,-2,-1), and the threshold is 0.
- R4: The magnitude is |H| + |V|, saturated to 4095. The edge flag is 1 only if the magnitude is strictly greater than the threshold.
- R5: For kernels whose coefficients sum to zero, a uniform neighbourhood is never flagged, even with a threshold of 0.
- R6: A pixel in the first or last row or column of its frame gets edge flag 0, but it still produces its output strobe.
- R7: The output for the pixel accepted as number n strobes in the cycle after pixel n+LINE_W+4 is accepted. Cycles with in_valid low freeze the pipeline and lose nothing.
- R8: Configuration writes take effect at the next accepted start-of-frame. A write in the same cycle as that start-of-frame applies from the frame after it.
- R9: After reset out_valid and out_edge are 0.
- R10: out_edge is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_eol | input | 1 | Pixel is the last of a line |
| in_pix | input | 8 | Greyscale pixel value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_data | input | 12 | Configuration write data |
| out_valid | output | 1 | Result strobe, one per accepted input |
| out_edge | output | 1 | Edge flag for the strobed result |

## Verification
The assertions assume that in_valid is held low through reset and that frames are well formed. Each line carries exactly LINE_W pixels and ends with in_eol, each frame has at least three lines, and in_sof marks only the first pixel. The bench sends only whole frames built from a height constant and a line-width parameter. It places configuration writes either between frames or in the middle of a frame, never on a start-of-frame cycle. Idle gaps are inserted between pixels at random, and a trailing frame pushes the last results of the frame before it out of the pipeline.

// File: rtl/edge3x3_det.sv
module edge3x3_det #(
  parameter int LINE_W = 64,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 4,
  parameter int MAG_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             cfg_we,
  input  logic [4:0]       cfg_addr,
  input  logic [MAG_W-1:0] cfg_data,
  output logic             out_valid,
  output logic             out_edge
);
  localparam int ACC_W  = PIX_W + COEF_W + 4;
  localparam int SUM_W  = ACC_W + 1;
  localparam int SR_LEN = 2 * LINE_W + 3;
  localparam int CW     = $clog2(LINE_W);
  localparam int ENT_W  = PIX_W + 2;
  localparam int KW     = 9 * COEF_W;

  function automatic logic [KW-1:0] sobel_k(input bit vert);
    logic [KW-1:0] v;
    int c;
    v = '0;
    for (int k = 0; k < 9; k++) begin
      int r;
      int q;
      r = k / 3;
      q = k % 3;
      if (!vert) c = (q - 1) * ((r == 1) ? 2 : 1);
      else       c = (1 - r) * ((q == 1) ? 2 : 1);
      v[k*COEF_W +: COEF_W] = COEF_W'(c);
    end
    return v;
  endfunction

  localparam logic [KW-1:0] KX_RST = sobel_k(1'b0);
  localparam logic [KW-1:0] KY_RST = sobel_k(1'b1);

  logic             acc;
  logic [KW-1:0]    kx_sh, ky_sh, kx_act, ky_act;
  logic [MAG_W-1:0] thr_sh, thr_act;

  assign acc = in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kx_sh <= KX_RST;  ky_sh <= KY_RST;  thr_sh <= '0;
      kx_act <= KX_RST; ky_act <= KY_RST; thr_act <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_addr < 5'd9)
          kx_sh[int'(cfg_addr)*COEF_W +: COEF_W] <= cfg_data[COEF_W-1:0];
        else if (cfg_addr < 5'd18)
          ky_sh[(int'(cfg_addr) - 9)*COEF_W +: COEF_W] <= cfg_data[COEF_W-1:0];
        else if (cfg_addr == 5'd18)
          thr_sh <= cfg_data;
      end
      if (acc && in_sof) begin
        kx_act <= kx_sh; ky_act <= ky_sh; thr_act <= thr_sh;
      end
    end
  end

  // delay line: {valid, frame parity, pixel}, newest at index 0
  logic [ENT_W-1:0] sr [SR_LEN];
  logic             par, pix_par;
  logic [CW-1:0]    col, colq, pix_col;

  assign pix_par = in_sof ? ~par : par;
  assign pix_col = in_sof ? '0 : col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SR_LEN; i++) sr[i] <= '0;
      par  <= 1'b0;
      col  <= '0;
      colq <= '0;
    end else if (acc) begin
      sr[0] <= {1'b1, pix_par, in_pix};
      for (int i = 1; i < SR_LEN; i++) sr[i] <= sr[i-1];
      par  <= pix_par;
      colq <= pix_col;
      col  <= (in_eol || pix_col == CW'(LINE_W - 1)) ? '0 : pix_col + 1'b1;
    end
  end

  logic [PIX_W-1:0] win [9];
  logic [8:0]       wv, wp;
  logic             interior;

  always_comb begin
    for (int k = 0; k < 9; k++) begin
      int t;
      t = (2 - k / 3) * LINE_W + 2 - k % 3;
      win[k] = sr[t][PIX_W-1:0];
      wp[k]  = sr[t][PIX_W];
      wv[k]  = sr[t][PIX_W+1];
    end
  end

  // newest column 0 or 1 means the centre sits in the last or first column
  assign interior = (&wv) && (wp == {9{wp[4]}}) && (colq > CW'(1));

  logic signed [ACC_W-1:0] gx_c, gy_c, pe;

  always_comb begin
    gx_c = '0;
    gy_c = '0;
    pe   = '0;
    for (int k = 0; k < 9; k++) begin
      pe   = ACC_W'(signed'({1'b0, win[k]}));
      gx_c = gx_c + pe * ACC_W'(signed'(kx_act[k*COEF_W +: COEF_W]));
      gy_c = gy_c + pe * ACC_W'(signed'(ky_act[k*COEF_W +: COEF_W]));
    end
  end

  logic                    s1_v, s1_in, s2_v, s2_in;
  logic signed [ACC_W-1:0] s1_gx, s1_gy;
  logic [MAG_W-1:0]        s1_thr, s2_thr, s2_mag, msat;
  logic [ACC_W-1:0]        ax, ay;
  logic [SUM_W-1:0]        msum;

  assign ax   = s1_gx[ACC_W-1] ? ACC_W'(-s1_gx) : ACC_W'(s1_gx);
  assign ay   = s1_gy[ACC_W-1] ? ACC_W'(-s1_gy) : ACC_W'(s1_gy);
  assign msum = {1'b0, ax} + {1'b0, ay};
  assign msat = (msum > SUM_W'({MAG_W{1'b1}})) ? '1 : msum[MAG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_in <= 1'b0; s1_gx <= '0; s1_gy <= '0; s1_thr <= '0;
      s2_v <= 1'b0; s2_in <= 1'b0; s2_mag <= '0; s2_thr <= '0;
      out_valid <= 1'b0;
      out_edge  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_edge  <= 1'b0;
      if (acc) begin
        s1_v  <= wv[4];  s1_in <= interior;
        s1_gx <= gx_c;   s1_gy <= gy_c;   s1_thr <= thr_act;
        s2_v  <= s1_v;   s2_in <= s1_in;
        s2_mag <= msat;  s2_thr <= s1_thr;
        out_valid <= s2_v;
        out_edge  <= s2_v && s2_in && (s2_mag > s2_thr);
      end
    end
  end

  // R10
  p_edge_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_edge |-> out_valid);

  // R7: a strobe only follows an accepted pixel
  p_out_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R7: idle cycles freeze the datapath
  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(s1_gx) && $stable(s1_gy) && $stable(s2_mag)));

  // R8: working configuration changes only on an accepted start-of-frame
  p_cfg_sof_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> ($stable(kx_act) && $stable(ky_act) && $stable(thr_act)));
endmodule

// File: tb/edge3x3_det_tb_top.sv
module edge3x3_det_tb_top;
  localparam int LW = 8;
  localparam int H  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic        out_valid, out_edge;

  always #5 clk = ~clk;

  edge3x3_det #(.LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eol(in_eol), .in_pix(in_pix), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .out_valid(out_valid), .out_edge(out_edge));

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  int kx_b[9], ky_b[9], thr_b;
  int kx_p[9], ky_p[9], thr_p;
  int img[H][LW];
  int acc_cnt = 0, out_cnt = 0, pushed = 0, first_out_acc = -1;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic bit exp_flag(int r, int c);
    int gx = 0, gy = 0, m;
    if (r == 0 || r == H-1 || c == 0 || c == LW-1) return 1'b0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        gx += img[r-1+i][c-1+j] * kx_b[i*3+j];
        gy += img[r-1+i][c-1+j] * ky_b[i*3+j];
      end
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    if (m > 4095) m = 4095;
    return m > thr_b;
  endfunction

  task automatic cfg_write(int a, int d);
    logic signed [3:0] cv;
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = 12'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    cv = 4'(d);
    if (a < 9) kx_p[a] = int'(cv);
    else if (a < 18) ky_p[a-9] = int'(cv);
    else if (a == 18) thr_p = d;
  endtask

  task automatic load_k(bit vert, int k0, int k1, int k2, int k3, int k4,
                        int k5, int k6, int k7, int k8);
    int v[9] = '{k0, k1, k2, k3, k4, k5, k6, k7, k8};
    for (int k = 0; k < 9; k++) cfg_write((vert ? 9 : 0) + k, v[k] & 15);
  endtask

  task automatic send_frame(string tag, int stall_pct);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < LW; c++) begin
        while ($urandom_range(99) < stall_pct) begin
          @(posedge clk); #1;
          in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
        end
        @(posedge clk); #1;
        if (r == 0 && c == 0) begin
          kx_b = kx_p; ky_b = ky_p; thr_b = thr_p;
        end
        in_valid = 1'b1;
        in_sof = (r == 0 && c == 0);
        in_eol = (c == LW-1);
        in_pix = 8'(img[r][c]);
        exp_q.push_back(exp_flag(r, c));
        if (r == 0 || r == H-1 || c == 0 || c == LW-1) tag_q.push_back("R6 border");
        else tag_q.push_back(tag);
        pushed++;
      end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic fill(int kind);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < LW; c++)
        case (kind)
          0: img[r][c] = 100;
          1: img[r][c] = (c < 4) ? 0 : 200;
          2: img[r][c] = (r < 3) ? 230 : 10;
          3: img[r][c] = (c < 3) ? 0 : 255;
          default: img[r][c] = $urandom_range(255);
        endcase
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (first_out_acc < 0) first_out_acc = acc_cnt;
        out_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected strobe", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(out_edge == e, t, int'(out_edge), int'(e));
        end
      end
      if (out_edge && !out_valid) check(1'b0, "R10 edge without strobe", 1, 0);
      if (in_valid) acc_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    kx_p = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
    ky_p = '{1, 2, 1, 0, 0, 0, -1, -2, -1};
    thr_p = 0;
    kx_b = kx_p; ky_b = ky_p; thr_b = thr_p;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
      check(out_edge == 1'b0, "R9 reset out_edge", int'(out_edge), 0);
    end

    fill(0); send_frame("R5 uniform thr0", 0);
    fill(1); send_frame("R3 reset Sobel step", 0);
    cfg_write(18, 300);
    fill(2); send_frame("R7 stalled row step", 40);
    load_k(1'b0, -1, 0, 1, -1, 0, 1, -1, 0, 1);
    load_k(1'b1, 1, 1, 1, 0, 0, 0, -1, -1, -1);
    cfg_write(19, 12'hfff);
    cfg_write(31, 12'hfff);
    fill(4); send_frame("R2 Prewitt random", 20);
    fill(1); send_frame("R1 Prewitt step", 0);
    load_k(1'b0, -8, 0, 7, -8, 0, 7, -8, 0, 7);
    cfg_write(18, 4095);
    fill(3);
    fork
      send_frame("R4 saturated equal thr", 10);
      begin
        repeat (20) @(posedge clk);
        cfg_write(18, 4094);
      end
    join
    send_frame("R4 saturated above thr", 10);
    fill(4); send_frame("R8 flush", 30);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(first_out_acc == LW + 5, "R7 first result latency", first_out_acc, LW + 5);
    check(exp_q.size() == LW + 4, "R7 results held in pipe", exp_q.size(), LW + 4);
    check(out_cnt == pushed - (LW + 4), "R1 output count", out_cnt, pushed - (LW + 4));
    done = 1;
    finish_up();
  end
endmodule